// File: doc/BRIEF.md
# Staggered Precharge/Evaluate Strobe Sequencer

This block generates the control strobes for a chain of cascaded dynamic logic tiles. Each tile has two logic planes, a first (horizontal) plane and a second (vertical) plane. Each plane is precharged and then evaluated, and never discharged beforehand. One free-running phase counter steps through a three-phase cycle: precharge, evaluate, hold. From that counter the block derives four active-high strobes per tile: horizontal precharge, horizontal evaluate, vertical precharge and vertical evaluate. Each strobe is high in exactly one phase of three.

The schedule of successive tiles is rotated so that data ripples down the chain. The vertical plane of a tile keeps its result for one phase after it evaluates, with both vertical strobes low. In that same phase the next tile evaluates its horizontal plane and consumes that result. All strobes are registered, so they change only at clock edges. An enable input pauses the sequence. While paused, every strobe is forced low and the counter keeps its position.

Top module: `dyn_strobe_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives every strobe low and sets `phase_o` to 0 at that edge. The first enabled edge after reset issues phase 0.
- R2: At each rising edge with `en` high, the block registers the current counter phase to `phase_o` and advances the counter 0→1→2→0. The encoding is 0 = precharge, 1 = evaluate, 2 = hold, given for tile 0. The strobes for that phase appear in the same cycle as `phase_o`.
- R3: When tile 0 is in phase 0, only `hpre_o[0]` is high among its four strobes.
- R4: When tile 0 is in phase 1, `heva_o[0]` and `vpre_o[0]` are high, and `hpre_o[0]` and `veva_o[0]` are low.
- R5: When tile 0 is in phase 2, only `veva_o[0]` is high. The horizontal plane holds because both horizontal strobes are low.
- R6: Tile k runs at local phase (phase_o + k) mod 3. As a result, tile k+1 has its horizontal evaluate high exactly while tile k is in its vertical hold phase. In that phase tile k has `hpre_o[k]` high and both of its vertical strobes low.
- R7: The precharge and evaluate strobes of the same plane of a tile are never high in the same cycle.
- R8: At a rising edge with `en` low and `rst` low, every strobe goes low and `phase_o` and the counter keep their values. The sequence resumes from the held phase when `en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sequence enable; low pauses and blanks strobes |
| hpre_o | output | NUM_TILES | Horizontal-plane precharge strobe per tile |
| heva_o | output | NUM_TILES | Horizontal-plane evaluate strobe per tile |
| vpre_o | output | NUM_TILES | Vertical-plane precharge strobe per tile |
| veva_o | output | NUM_TILES | Vertical-plane evaluate strobe per tile |
| phase_o | output | 2 | Global phase of the strobes now shown (tile 0 phase) |

## Verification
The hardest behaviour to reach is a pause that starts in each of the three phases, followed by a clean resume from the held phase. A reset that arrives while the counter is in a nonzero phase is equally hard to reach. Directed segments stop the enable once in each phase and assert reset mid-cycle. A long seeded random stretch then toggles enable often and sometimes asserts reset. This mixes short and long runs across all phase alignments and all tile rotations.

// File: rtl/dyn_strobe_pkg.sv
package dyn_strobe_pkg;

   localparam int unsigned PHASE_COUNT = 3;
   localparam int unsigned PHASE_W     = 2;

   typedef enum logic [PHASE_W-1:0] {
      PH_PRE  = 2'd0,
      PH_EVA  = 2'd1,
      PH_HOLD = 2'd2
   } phase_e;

   typedef struct packed {
      logic hpre;
      logic heva;
      logic vpre;
      logic veva;
   } strobe_t;

   // Map one local phase to the four plane strobes of a tile.
   function automatic strobe_t strobe_decode(input phase_e p);
      strobe_t s;
      s = '0;
      case (p)
         PH_PRE:  s.hpre = 1'b1;
         PH_EVA:  begin
            s.heva = 1'b1;
            s.vpre = 1'b1;
         end
         PH_HOLD: s.veva = 1'b1;
         default: s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/dss_phase_ctr.sv
module dss_phase_ctr
   import dyn_strobe_pkg::*;
#(
   parameter int unsigned PHASES = PHASE_COUNT
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               adv,
   output logic [PHASE_W-1:0] ph_o
);

   localparam logic [PHASE_W-1:0] LAST = PHASE_W'(PHASES - 1);

   generate
      if (PHASES < 2 || PHASES > (1 << PHASE_W)) begin : g_bad_phases
         $error("dss_phase_ctr: PHASES out of range");
      end
   endgenerate

   logic [PHASE_W-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= '0;
      end else if (adv) begin
         ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
      end
   end

   assign ph_o = ph_q;

endmodule

// File: rtl/dss_tile_ctl.sv
module dss_tile_ctl
   import dyn_strobe_pkg::*;
#(
   parameter int unsigned TILE_IDX = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [PHASE_W-1:0] gph_i,
   output strobe_t            strb_o
);

   localparam int unsigned  OFS   = TILE_IDX % PHASE_COUNT;
   localparam int unsigned  SUM_W = PHASE_W + 1;

   logic [SUM_W-1:0] sum;
   logic [PHASE_W-1:0] lph;
   strobe_t strb_d;
   strobe_t strb_q;

   // Rotate the global phase by this tile's constant offset, modulo 3.
   always_comb begin
      sum = {1'b0, gph_i} + SUM_W'(OFS);
      if (sum >= SUM_W'(PHASE_COUNT)) begin
         lph = PHASE_W'(sum - SUM_W'(PHASE_COUNT));
      end else begin
         lph = PHASE_W'(sum);
      end
      strb_d = strobe_decode(phase_e'(lph));
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         strb_q <= '0;
      end else begin
         strb_q <= strb_d;
      end
   end

   assign strb_o = strb_q;

endmodule

// File: rtl/dyn_strobe_seq.sv
module dyn_strobe_seq
   import dyn_strobe_pkg::*;
#(
   parameter int unsigned NUM_TILES = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   output logic [NUM_TILES-1:0] hpre_o,
   output logic [NUM_TILES-1:0] heva_o,
   output logic [NUM_TILES-1:0] vpre_o,
   output logic [NUM_TILES-1:0] veva_o,
   output logic [1:0]           phase_o
);

   localparam int unsigned MAX_TILES = 1024;

   generate
      if (NUM_TILES < 1 || NUM_TILES > MAX_TILES) begin : g_bad_tiles
         $error("dyn_strobe_seq: NUM_TILES out of range");
      end
   endgenerate

   logic [PHASE_W-1:0] gph;
   logic [PHASE_W-1:0] phase_q;

   dss_phase_ctr #(.PHASES(PHASE_COUNT)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .adv  (en),
      .ph_o (gph)
   );

   // The phase register follows the strobe registers, so both describe one phase.
   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
      end else if (en) begin
         phase_q <= gph;
      end
   end

   assign phase_o = phase_q;

   generate
      for (genvar k = 0; k < NUM_TILES; k++) begin : g_tile
         strobe_t s;
         dss_tile_ctl #(.TILE_IDX(k)) u_tile (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .gph_i  (gph),
            .strb_o (s)
         );
         assign hpre_o[k] = s.hpre;
         assign heva_o[k] = s.heva;
         assign vpre_o[k] = s.vpre;
         assign veva_o[k] = s.veva;
      end
   endgenerate

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
   parameter int unsigned NUM_TILES = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 en,
   input logic [NUM_TILES-1:0] hpre_o,
   input logic [NUM_TILES-1:0] heva_o,
   input logic [NUM_TILES-1:0] vpre_o,
   input logic [NUM_TILES-1:0] veva_o,
   input logic [1:0]           phase_o
);

   // Edges seen since the last reset, saturating, so $past never reaches before reset.
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (rst) age <= '0;
      else if (age != 2'd3) age <= age + 1'b1;
   end

   p_phase_legal_r2: assert property (@(posedge clk) disable iff (rst)
      phase_o != 2'd3);

   p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd2 && $past(en) && $past(en, 2)) |->
      phase_o == (($past(phase_o) == 2'd2) ? 2'd0 : $past(phase_o) + 2'd1));

   p_pre_only_r3: assert property (@(posedge clk) disable iff (rst)
      hpre_o[0] |-> (phase_o == 2'd0 && !heva_o[0] && !vpre_o[0] && !veva_o[0]));

   p_eval_pair_r4: assert property (@(posedge clk) disable iff (rst)
      heva_o[0] |-> (phase_o == 2'd1 && vpre_o[0] && !veva_o[0]));

   p_vert_eval_r5: assert property (@(posedge clk) disable iff (rst)
      veva_o[0] |-> (phase_o == 2'd2 && !hpre_o[0] && !heva_o[0] && !vpre_o[0]));

   p_h_excl_r7: assert property (@(posedge clk) disable iff (rst)
      (hpre_o & heva_o) == '0);

   p_v_excl_r7: assert property (@(posedge clk) disable iff (rst)
      (vpre_o & veva_o) == '0);

   p_idle_blank_r8: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && !$past(en)) |->
      ((hpre_o | heva_o | vpre_o | veva_o) == '0));

   p_idle_freeze_r8: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd2 && !$past(en)) |-> $stable(phase_o));

   generate
      for (genvar k = 0; k + 1 < NUM_TILES; k++) begin : g_stag
         p_handoff_r6: assert property (@(posedge clk) disable iff (rst)
            heva_o[k+1] |-> (hpre_o[k] && !vpre_o[k] && !veva_o[k]));
      end
   endgenerate

endmodule

bind dyn_strobe_seq dss_checker #(.NUM_TILES(NUM_TILES)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .en      (en),
   .hpre_o  (hpre_o),
   .heva_o  (heva_o),
   .vpre_o  (vpre_o),
   .veva_o  (veva_o),
   .phase_o (phase_o)
);

// File: tb/dyn_strobe_seq_tb.sv
`timescale 1ns/1ps
module dyn_strobe_seq_tb;

   localparam int NT = 4;
   localparam time TCLK = 20ns;

   logic clk = 1'b0;
   logic rst, en;
   logic [NT-1:0] hpre_o, heva_o, vpre_o, veva_o;
   logic [1:0] phase_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Reference model state
   int m_cnt = 0;
   int m_ph  = 0;
   bit m_on  = 1'b0;

   always #(TCLK/2) clk = ~clk;

   dyn_strobe_seq #(.NUM_TILES(NT)) u_dut (
      .clk(clk), .rst(rst), .en(en),
      .hpre_o(hpre_o), .heva_o(heva_o), .vpre_o(vpre_o), .veva_o(veva_o),
      .phase_o(phase_o)
   );

   function automatic int local_ph(input int g, input int k);
      return (g + k) % 3;
   endfunction

   // Expected strobe vector: sel 0=hpre 1=heva 2=vpre 3=veva
   function automatic logic [NT-1:0] exp_vec(input int sel, input int g, input bit on);
      logic [NT-1:0] v;
      v = '0;
      for (int k = 0; k < NT; k++) begin
         int lp;
         lp = local_ph(g, k);
         case (sel)
            0: v[k] = on && (lp == 0);
            1: v[k] = on && (lp == 1);
            2: v[k] = on && (lp == 1);
            default: v[k] = on && (lp == 2);
         endcase
      end
      return v;
   endfunction

   task automatic chk(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic r, input logic e, input string ctx);
      string tag;
      rst = r;
      en  = e;
      @(posedge clk);
      if (r) begin
         m_cnt = 0; m_ph = 0; m_on = 1'b0;
      end else if (e) begin
         m_ph = m_cnt; m_on = 1'b1; m_cnt = (m_cnt + 1) % 3;
      end else begin
         m_on = 1'b0;
      end
      @(negedge clk);
      if (r) tag = "R1";
      else if (!e) tag = "R8";
      else tag = ctx;
      chk({tag, " phase"}, NT'(phase_o), NT'(m_ph));
      chk((tag == ctx && ctx == "rnd") ? "R3 hpre" : {tag, " hpre"}, hpre_o, exp_vec(0, m_ph, m_on));
      chk((tag == ctx && ctx == "rnd") ? "R4 heva" : {tag, " heva"}, heva_o, exp_vec(1, m_ph, m_on));
      chk((tag == ctx && ctx == "rnd") ? "R4 vpre" : {tag, " vpre"}, vpre_o, exp_vec(2, m_ph, m_on));
      chk((tag == ctx && ctx == "rnd") ? "R5 veva" : {tag, " veva"}, veva_o, exp_vec(3, m_ph, m_on));
      // R7: no plane sees precharge and evaluate together
      chk("R7 h-excl", hpre_o & heva_o, '0);
      chk("R7 v-excl", vpre_o & veva_o, '0);
      // R6: next tile's horizontal evaluate sits in this tile's vertical hold
      for (int k = 0; k + 1 < NT; k++) begin
         if (heva_o[k+1]) chk("R6 handoff", NT'({hpre_o[k], vpre_o[k], veva_o[k]}), NT'(3'b100));
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst = 1'b1;
      en  = 1'b0;
      @(negedge clk);
      // R1: reset state
      step(1'b1, 1'b0, "R1");
      step(1'b1, 1'b1, "R1");
      // R2: full sequence, two cycles of three phases, all tiles rotated (R6)
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R2");
      // R8: pause in each of the three phases, then resume
      for (int p = 0; p < 3; p++) begin
         step(1'b0, 1'b0, "R8");
         step(1'b0, 1'b0, "R8");
         step(1'b0, 1'b1, "R8");
      end
      // R1: reset while in a nonzero phase
      step(1'b0, 1'b1, "R1");
      step(1'b1, 1'b1, "R1");
      step(1'b0, 1'b1, "R1");
      // Random stretch
      for (int i = 0; i < 3000; i++) begin
         logic r, e;
         r = ($urandom % 100) < 2;
         e = ($urandom % 100) < 70;
         step(r, e, "rnd");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(TCLK * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule